// File: doc/BRIEF.md
# Latched Second-Level Interrupt Controller

This block gathers up to 32 peripheral interrupt requests and reduces them to one interrupt line for a parent controller. Each source has one status bit and one mask bit. Software reads the status, enables or disables sources, and acknowledges them through a small memory-mapped register port. Every register is one bus word wide and holds one bit per source.

The mask is never written as a whole word. One offset sets mask bits wherever the written data has ones. Another offset clears mask bits wherever the written data has ones. Bits written as zero keep their value, so two agents can change different sources without a read-modify-write.

The parameter `LATCHED` picks one of two variants when the block is built. The latched variant turns each rising edge of a request into a sticky status bit, and software clears that bit through a write-one-to-clear register. The level variant shows the live request levels as status and has no acknowledge register. Because of that, the register offsets differ between the two variants.

Top module: `l2_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, meaning the source is disabled. Every latched status bit is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: In the latched variant, a status bit becomes 1 at the first clock edge where its request is sampled at 1 after being sampled at 0 at the edge before. It then stays 1 until it is acknowledged. Requests are treated as 0 before the first edge after reset.
- R3: In the latched variant, a write to offset 0x08 clears every status bit whose data bit is 1. Bits written as 0 are unchanged. A write of all ones flushes every source.
- R4: In the latched variant, if a new rising edge and an acknowledge of the same bit land on the same clock edge, the bit ends up set.
- R5: A write to the mask-set offset makes every mask bit whose data bit is 1 equal to 1. A write to the mask-clear offset makes those bits 0. Data bits written as 0 leave the mask alone. The mask-set offset is 0x10 in the latched variant and 0x08 in the level variant. The mask-clear offset is 0x14 in the latched variant and 0x0C in the level variant.
- R6: The mask is read back at offset 0x0C in the latched variant and at 0x04 in the level variant. A bit value of 1 means the source is disabled.
- R7: `irq_out` is a register. After each clock edge it equals the OR of (status AND NOT mask) as those values stood just before that edge.
- R8: In the level variant, status at offset 0x00 is the live request vector. The variant has no acknowledge register, so 0x08 acts as mask-set and offsets 0x10 and 0x14 have no effect.
- R9: Undefined offsets read as zero. So do the write-only offsets: acknowledge, mask-set and mask-clear. Writes to the status offset and to the mask readback offset change nothing.
- R10: `bus_rdata` is registered. After a clock edge it holds the register selected by `bus_addr` at that edge, with the value the register had before any write or capture at that same edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Interrupt request inputs, one per source |
| bus_addr | input | ADDR_W | Byte offset of the register accessed this cycle |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for the address of the previous cycle |
| irq_out | output | 1 | Aggregated interrupt to the parent controller |

## Verification
The bench goes after four cases. The first is an acknowledge that lands on the same edge as a fresh rising edge of that source: a design that lets the acknowledge win loses that interrupt for good. The second is partial acknowledge and mask writes, where a design that writes the data word instead of OR-ing or AND-ing it in would disturb sources that software never touched. The third is writes to the read-only offsets and reads of write-only or undefined offsets, where a loose address decoder would corrupt the mask or return stale data. The fourth is the level variant's shifted offset map, where reusing the latched offsets would send mask-set writes into a missing acknowledge register.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ACK,
    SEL_MSTAT,
    SEL_MSET,
    SEL_MCLR
  } reg_sel_e;

  // Offset map: the two variants place the same registers differently.
  function automatic reg_sel_e decode_offset(input logic [7:0] off, input bit latched);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (latched) begin
      case (off)
        8'h00:   sel = SEL_STATUS;
        8'h08:   sel = SEL_ACK;
        8'h0C:   sel = SEL_MSTAT;
        8'h10:   sel = SEL_MSET;
        8'h14:   sel = SEL_MCLR;
        default: sel = SEL_NONE;
      endcase
    end else begin
      case (off)
        8'h00:   sel = SEL_STATUS;
        8'h04:   sel = SEL_MSTAT;
        8'h08:   sel = SEL_MSET;
        8'h0C:   sel = SEL_MCLR;
        default: sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

  // True when a read of this selection returns register contents.
  function automatic bit is_readable(input reg_sel_e sel);
    return (sel == SEL_STATUS) || (sel == SEL_MSTAT);
  endfunction

endpackage

// File: rtl/l2irq_decode.sv
module l2irq_decode
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output reg_sel_e           sel,
  output logic [NUM_SRC-1:0] ack_ev,
  output logic [NUM_SRC-1:0] mset_ev,
  output logic [NUM_SRC-1:0] mclr_ev,
  output logic               rd_undef
);

  logic in_window;

  // Only the low byte carries an offset; anything above it is undefined.
  assign in_window = ((bus_addr >> 8) == '0);

  always_comb begin
    sel = SEL_NONE;
    if (in_window) sel = decode_offset(bus_addr[7:0], LATCHED);
  end

  assign ack_ev   = (bus_we && sel == SEL_ACK)  ? bus_wdata : '0;
  assign mset_ev  = (bus_we && sel == SEL_MSET) ? bus_wdata : '0;
  assign mclr_ev  = (bus_we && sel == SEL_MCLR) ? bus_wdata : '0;
  assign rd_undef = !is_readable(sel);

endmodule

// File: rtl/l2irq_capture.sv
module l2irq_capture #(
  parameter int NUM_SRC = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] ack_ev,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] rise_ev
);

  generate
    if (LATCHED) begin : g_latched
      logic [NUM_SRC-1:0] req_q;
      logic [NUM_SRC-1:0] stat_q;

      assign rise_ev = src_req & ~req_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req_q  <= '0;
          stat_q <= '0;
        end else begin
          req_q  <= src_req;
          // A fresh edge is ORed in after the acknowledge, so it survives.
          stat_q <= (stat_q & ~ack_ev) | rise_ev;
        end
      end

      assign status = stat_q;
    end else begin : g_level
      logic unused_ack;
      assign unused_ack = ^ack_ev;
      assign rise_ev    = '0;
      assign status     = src_req;
    end
  endgenerate

endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] mset_ev,
  input  logic [NUM_SRC-1:0] mclr_ev,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] pend
);

  logic [NUM_SRC-1:0] mask_q;

  function automatic logic [NUM_SRC-1:0] apply_w1(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] set_bits,
    input logic [NUM_SRC-1:0] clr_bits
  );
    return (cur | set_bits) & ~clr_bits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= apply_w1(mask_q, mset_ev, mclr_ev);
  end

  assign mask = mask_q;
  assign pend = status & ~mask_q;

endmodule

// File: rtl/l2_irq_ctrl.sv
module l2_irq_ctrl
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out
);

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] ack_ev;
  logic [NUM_SRC-1:0] mset_ev;
  logic [NUM_SRC-1:0] mclr_ev;
  logic               rd_undef;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] rise_ev;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] rdata_q;
  logic               irq_q;

  l2irq_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_decode (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .sel      (sel),
    .ack_ev   (ack_ev),
    .mset_ev  (mset_ev),
    .mclr_ev  (mclr_ev),
    .rd_undef (rd_undef)
  );

  l2irq_capture #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_req(src_req),
    .ack_ev (ack_ev),
    .status (status_q),
    .rise_ev(rise_ev)
  );

  l2irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .mset_ev(mset_ev),
    .mclr_ev(mclr_ev),
    .status (status_q),
    .mask   (mask_q),
    .pend   (pend)
  );

  function automatic logic [NUM_SRC-1:0] read_mux(
    input reg_sel_e           s,
    input logic [NUM_SRC-1:0] st,
    input logic [NUM_SRC-1:0] mk
  );
    case (s)
      SEL_STATUS: return st;
      SEL_MSTAT:  return mk;
      default:    return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= read_mux(sel, status_q, mask_q);
      irq_q   <= |pend;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

endmodule

// File: rtl/l2_irq_ctrl_chk.sv
module l2_irq_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter bit LATCHED = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] rise_ev,
  input logic [NUM_SRC-1:0] ack_ev,
  input logic [NUM_SRC-1:0] mset_ev,
  input logic [NUM_SRC-1:0] mclr_ev,
  input logic [NUM_SRC-1:0] pend,
  input logic               rd_undef,
  input logic [NUM_SRC-1:0] bus_rdata,
  input logic               irq_out
);

  assert_reset_mask_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == '1));

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & $past(mset_ev)) == $past(mset_ev)));

  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_q & $past(mclr_ev)) == '0));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(mset_ev | mclr_ev)) == '0));

  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|pend)));

  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_undef |=> (bus_rdata == '0));

  generate
    if (LATCHED) begin : g_lat_chk
      assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(ack_ev & ~rise_ev)) == '0));

      assert_edge_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(rise_ev)) == $past(rise_ev)));

      assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~status_q) & $past(status_q) & ~$past(ack_ev)) == '0));
    end else begin : g_lvl_chk
      assert_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ev == '0);
    end
  endgenerate

endmodule

bind l2_irq_ctrl l2_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .status_q (status_q),
  .mask_q   (mask_q),
  .rise_ev  (rise_ev),
  .ack_ev   (ack_ev),
  .mset_ev  (mset_ev),
  .mclr_ev  (mclr_ev),
  .pend     (pend),
  .rd_undef (rd_undef),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out)
);

// File: tb/l2_irq_ctrl_tb.sv
module l2_irq_ctrl_tb;

  localparam int N = 32;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr  = '0;
  logic         we    = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] src   = '0;
  logic [N-1:0] rd_a, rd_b;
  logic         irq_a, irq_b;

  always #10 clk = ~clk;

  l2_irq_ctrl #(.NUM_SRC(N), .ADDR_W(8), .LATCHED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rd_a), .irq_out(irq_a));

  l2_irq_ctrl #(.NUM_SRC(N), .ADDR_W(8), .LATCHED(1'b0)) u_dut_lvl (
    .clk(clk), .rst_n(rst_n), .src_req(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rd_b), .irq_out(irq_b));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state: latched status/mask/previous request, level mask.
  logic [N-1:0] st_a = '0, mk_a = '1, prev_a = '0, mk_b = '1;

  function automatic logic [N-1:0] model_read(bit lat, logic [7:0] a,
                                               logic [N-1:0] st, logic [N-1:0] mk);
    logic [7:0] mk_off;
    mk_off = lat ? 8'h0C : 8'h04;
    if (a == 8'h00)   return st;
    if (a == mk_off)  return mk;
    return '0;
  endfunction

  function automatic logic [N-1:0] model_mask(bit lat, logic [7:0] a, logic w,
                                              logic [N-1:0] d, logic [N-1:0] mk);
    logic [7:0] set_off, clr_off;
    set_off = lat ? 8'h10 : 8'h08;
    clr_off = lat ? 8'h14 : 8'h0C;
    if (!w)           return mk;
    if (a == set_off) return mk | d;
    if (a == clr_off) return mk & ~d;
    return mk;
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; drives one bus cycle and checks the outcome.
  task automatic tick(string tag, logic [7:0] a, logic w, logic [N-1:0] d, logic [N-1:0] s);
    logic [N-1:0] e_rd_a, e_rd_b;
    logic         e_irq_a, e_irq_b;
    addr = a; we = w; wdata = d; src = s;
    e_rd_a  = model_read(1'b1, a, st_a, mk_a);
    e_irq_a = |(st_a & ~mk_a);
    e_rd_b  = model_read(1'b0, a, s, mk_b);
    e_irq_b = |(s & ~mk_b);
    st_a   = (st_a & ~((w && a == 8'h08) ? d : '0)) | (s & ~prev_a);
    prev_a = s;
    mk_a   = model_mask(1'b1, a, w, d, mk_a);
    mk_b   = model_mask(1'b0, a, w, d, mk_b);
    @(negedge clk);
    check({tag, " latched rdata"}, rd_a, e_rd_a);
    check({tag, " latched irq"},   N'(irq_a), N'(e_irq_a));
    check({tag, " level rdata"},   rd_b, e_rd_b);
    check({tag, " level irq"},     N'(irq_b), N'(e_irq_b));
  endtask

  function automatic logic [7:0] pick_addr(int unsigned r);
    case (r % 9)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h0C;
      4: return 8'h10; 5: return 8'h14; 6: return 8'h18; 7: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset latched irq",   N'(irq_a), '0);
    check("R1 reset level irq",     N'(irq_b), '0);
    check("R1 reset latched rdata", rd_a, '0);
    check("R1 reset level rdata",   rd_b, '0);
    rst_n = 1'b1;

    tick("R1 mask after reset", 8'h0C, 1'b0, '0, '0);
    tick("R6 R1 level mask read", 8'h04, 1'b0, '0, '0);
    tick("R1 status after reset", 8'h00, 1'b0, '0, '0);

    tick("R5 latched unmask", 8'h14, 1'b1, 32'h0000_00FF, '0);
    tick("R5 level unmask",   8'h0C, 1'b1, 32'h0000_00FF, '0);
    tick("R6 latched mask",   8'h0C, 1'b0, '0, '0);
    tick("R6 level mask",     8'h04, 1'b0, '0, '0);

    tick("R2 rise bit4",  8'h00, 1'b0, '0, 32'h10);
    tick("R2 R7 hold",    8'h00, 1'b0, '0, '0);
    tick("R2 rise bit2",  8'h00, 1'b0, '0, 32'h04);
    tick("R3 ack bit4",   8'h08, 1'b1, 32'h10, 32'h04);
    tick("R3 bit2 kept",  8'h00, 1'b0, '0, 32'h04);

    tick("R4 prime",      8'h00, 1'b0, '0, '0);
    tick("R4 edge+ack",   8'h08, 1'b1, 32'h20, 32'h20);
    tick("R4 edge wins",  8'h00, 1'b0, '0, 32'h20);

    tick("R9 write status",  8'h00, 1'b1, '1, '0);
    tick("R9 write mstat",   8'h0C, 1'b1, '1, '0);
    tick("R9 write mstat l", 8'h04, 1'b1, '1, '0);
    tick("R9 undefined",     8'h18, 1'b0, '0, '0);
    tick("R9 ack reads 0",   8'h08, 1'b0, '0, '0);
    tick("R9 status intact", 8'h00, 1'b0, '0, '0);

    tick("R10 read vs edge", 8'h00, 1'b0, '0, 32'h40);
    tick("R10 next read",    8'h00, 1'b0, '0, 32'h40);

    tick("R8 live A5",    8'h00, 1'b0, '0, 32'hA5);
    tick("R8 live 5A",    8'h00, 1'b0, '0, 32'h5A);
    tick("R8 no ack reg", 8'h10, 1'b1, 32'hFF00_0000, '0);
    tick("R8 mask read",  8'h04, 1'b0, '0, '0);

    tick("R3 flush mask", 8'h10, 1'b1, '1, '0);
    tick("R3 flush all",  8'h08, 1'b1, '1, '0);
    tick("R3 flushed",    8'h00, 1'b0, '0, '0);

    for (int i = 0; i < 3000; i++) begin
      rs = $urandom() & $urandom();
      tick("R2 R5 R6 R7 R9 random", pick_addr($urandom()), 1'($urandom() % 3 == 0),
           $urandom(), rs);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule